// File: doc/BRIEF.md
# Guarded Self-Timed Byte Store Controller

This block gives a processor three byte-wide registers for a 128-location non-volatile byte store: an address register, a data register and a control register. The store itself is a behavioural array that lives inside the block. Software reads a byte by loading the address and setting the read strobe. The byte lands in the data register one clock later.

A write needs two steps. Software first sets an arming bit, and then sets the write strobe while the arming bit is still live. The block then commits the byte after a fixed, parameterised number of clock cycles, and a busy flag stays visible for that whole interval. A commit that is under way runs to the end even if the synchronous reset is pulled in the middle of it.

The block also drives a stall output that holds the processor for a short time after each accepted strobe, with a different length for reads and writes. It drives a ready interrupt request that is high whenever the store is idle and the interrupt is enabled.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: The store holds 128 bytes at linear locations 0 to 127, selected by a 7-bit address. Every location, including 0 and 127, returns the last byte committed to it. The register select codes are 0 for address, 1 for data and 2 for control.
- R2: The address register keeps the 7-bit field in bits 6..0 and is not given a value by reset. Bit 7 ignores writes and always reads as 0.
- R3: Control bit 2 arms a write. The arm reads back on control bit 2 for 4 cycles and then clears by itself. A write strobe (control bit 1) is accepted only if the arm was already set before the strobe's own bus write, and an accepted strobe clears the arm.
- R4: From the clock edge that accepts a write strobe, busy (the port, also readable on control bit 1) is high for exactly WR_CYCLES cycles. The byte is committed to the store when busy falls.
- R5: The interrupt request equals the interrupt enable (control bit 3) ANDed with "not busy".
- R6: Reset clears the arm, the interrupt enable, the stall and the data register. A commit that is in progress carries on through reset and lands on time.
- R7: An accepted write strobe raises stall for 2 cycles. An accepted read strobe raises it for 4 cycles. A strobe that is not accepted does not raise stall.
- R8: While busy, read strobes and write strobes are ignored. The data register keeps its value, and the ongoing commit keeps the address and byte it captured.
- R9: An accepted read strobe (control bit 0) loads the data register at the same edge with the byte stored at the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| bus_we | input | 1 | Register write enable for this cycle |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| busy_o | output | 1 | A commit is in progress |
| irq_o | output | 1 | Ready interrupt request |
| stall_o | output | 1 | Processor hold after an accepted strobe |

## Verification
Take P as the edge that samples an accepted strobe. Busy is then due high from P through P+WR_CYCLES-1 and low at P+WR_CYCLES. Stall is due high for P..P+1 after a write and for P..P+3 after a read. Read data is due in the data register at P, and the arm readback is due high through A+3 and low at A+4, where A is the edge that wrote the arm. The driver tasks return at the falling edge that follows the sampling edge and file each expected level with its absolute cycle number, and the monitor compares each level only at the falling edge of that exact cycle, so any early or late transition shows up as a mismatch.

// File: rtl/nvm_pkg.sv
// Shared definitions for the guarded byte store controller.
// Assumes the control register is at least 4 bits wide.
package nvm_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_RD_BIT  = 0;
    localparam int CTRL_WR_BIT  = 1;
    localparam int CTRL_ARM_BIT = 2;
    localparam int CTRL_IE_BIT  = 3;
endpackage

// File: rtl/nvm_arm_guard.sv
// Arming window for the two-step write procedure.
// Setting the arm opens a window of ARM_CYCLES cycles. The window closes on
// expiry or when a write consumes it. Assumes ARM_CYCLES >= 1.
module nvm_arm_guard #(
    parameter int ARM_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic consume_i,
    output logic armed_o
);
    localparam int AW = $clog2(ARM_CYCLES + 1);

    logic [AW-1:0] win_q;

    // Window counter: load on set, clear on consume or reset, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               win_q <= '0;
        else if (consume_i)       win_q <= '0;
        else if (set_i)           win_q <= AW'(ARM_CYCLES);
        else if (win_q != '0)     win_q <= win_q - 1'b1;
    end

    assign armed_o = (win_q != '0);

    assert_arm_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && !consume_i |=> armed_o);
    assert_arm_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |=> !armed_o);
endmodule

// File: rtl/nvm_stall_timer.sv
// Processor hold generator. An accepted read holds for RD_STALL cycles and an
// accepted write for WR_STALL cycles. Assumes both strobes never arrive together.
module nvm_stall_timer #(
    parameter int RD_STALL = 4,
    parameter int WR_STALL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_go_i,
    input  logic wr_go_i,
    output logic stall_o
);
    localparam int MAXS = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
    localparam int SW   = $clog2(MAXS + 1);

    logic [SW-1:0] hold_q;

    // Hold counter: load the length of the strobe, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_q <= '0;
        else if (rd_go_i)        hold_q <= SW'(RD_STALL);
        else if (wr_go_i)        hold_q <= SW'(WR_STALL);
        else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end

    assign stall_o = (hold_q != '0);

    assert_write_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go_i |=> stall_o);
endmodule

// File: rtl/nvm_write_engine.sv
// Self-timed commit engine. On start it captures the address and the byte,
// stays busy for WR_CYCLES cycles and then issues a single store write.
// While busy it deliberately ignores reset, so a commit always lands.
// Assumes WR_CYCLES >= 2.
module nvm_write_engine #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o
);
    localparam int CNT_W = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;

    logic              busy_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [DATA_W-1:0] tgt_data_q;

    // Commit sequencing: a running commit has priority over reset.
    always_ff @(posedge clk) begin
        if (busy_q) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end else if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (start_i) begin
            busy_q     <= 1'b1;
            left_q     <= CNT_W'(WR_CYCLES - 1);
            tgt_addr_q <= addr_i;
            tgt_data_q <= data_i;
        end
    end

    assign busy_o     = busy_q;
    assign mem_we_o   = busy_q && (left_q == '0);
    assign mem_addr_o = tgt_addr_q;
    assign mem_data_o = tgt_data_q;

    assert_start_goes_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);
    assert_commit_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !busy_o);
endmodule

// File: rtl/nvm_cell_array.sv
// Behavioural byte store: one synchronous write port and one combinational
// read port. It has no reset, because its contents are meant to persist.
module nvm_cell_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store update from the commit engine.
    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/nvm_byte_ctrl.sv
// Top of the guarded byte store controller. It decodes register writes into
// read, arm and write strobes, holds the address and data registers, and
// combines busy and enable into the interrupt request.
// Assumes DATA_W > ADDR_W and DATA_W >= 4.
module nvm_byte_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 8,
    parameter int WR_CYCLES  = 16,
    parameter int ARM_CYCLES = 4,
    parameter int RD_STALL   = 4,
    parameter int WR_STALL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_sel,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy_o,
    output logic              irq_o,
    output logic              stall_o
);
    localparam int PAD_W = DATA_W - ADDR_W;

    reg_sel_e          sel;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              ie_q;
    logic              armed;
    logic              ctrl_wr, rd_go, wr_go, arm_set;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    assign sel     = reg_sel_e'(bus_sel);
    assign ctrl_wr = rst_n && bus_we && (sel == SEL_CTRL);
    assign rd_go   = ctrl_wr && bus_wdata[CTRL_RD_BIT] && !busy_o;
    assign wr_go   = ctrl_wr && bus_wdata[CTRL_WR_BIT] && armed && !busy_o;
    assign arm_set = ctrl_wr && bus_wdata[CTRL_ARM_BIT];

    // Address register: 7-bit field, no reset value on purpose.
    always_ff @(posedge clk) begin
        if (rst_n && bus_we && (sel == SEL_ADDR)) addr_q <= bus_wdata[ADDR_W-1:0];
    end

    // Data register: loaded by the bus or by an accepted read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                        data_q <= '0;
        else if (rd_go)                    data_q <= mem_rdata;
        else if (bus_we && sel == SEL_DATA) data_q <= bus_wdata;
    end

    // Interrupt enable: follows control bit 3 on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_q <= 1'b0;
        else if (ctrl_wr) ie_q <= bus_wdata[CTRL_IE_BIT];
    end

    nvm_arm_guard #(.ARM_CYCLES(ARM_CYCLES)) u_guard (
        .clk(clk), .rst_n(rst_n), .set_i(arm_set), .consume_i(wr_go), .armed_o(armed)
    );

    nvm_write_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)) u_engine (
        .clk(clk), .rst_n(rst_n), .start_i(wr_go), .addr_i(addr_q), .data_i(data_q),
        .busy_o(busy_o), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_wdata)
    );

    nvm_stall_timer #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) u_stall (
        .clk(clk), .rst_n(rst_n), .rd_go_i(rd_go), .wr_go_i(wr_go), .stall_o(stall_o)
    );

    nvm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(mem_wdata),
        .raddr_i(addr_q), .rdata_o(mem_rdata)
    );

    assign irq_o = ie_q && !busy_o;

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_ADDR: bus_rdata = {{PAD_W{1'b0}}, addr_q};
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: begin
                bus_rdata[CTRL_WR_BIT]  = busy_o;
                bus_rdata[CTRL_ARM_BIT] = armed;
                bus_rdata[CTRL_IE_BIT]  = ie_q;
            end
            default:  bus_rdata = '0;
        endcase
    end

    assert_commit_was_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(armed));
    assert_busy_read_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ctrl_wr && bus_wdata[CTRL_RD_BIT] |=> $stable(data_q));
    assert_read_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> stall_o);
    assert_irq_on_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ie_q && $fell(busy_o) |-> irq_o);
endmodule

// File: tb/nvm_byte_ctrl_tb.sv
// Scoreboard bench: driver tasks file timed expectations, a monitor compares them.
module nvm_byte_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WR_CYC     = 16;
    localparam logic [7:0] B_RD  = 8'h01;
    localparam logic [7:0] B_WR  = 8'h02;
    localparam logic [7:0] B_ARM = 8'h04;
    localparam logic [7:0] B_IE  = 8'h08;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd3;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       busy_o, irq_o, stall_o;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] ie_b = 8'h00;

    typedef struct {
        int    due;
        int    sig;
        logic  val;
        string req;
    } exp_t;
    exp_t sb_q[$];

    nvm_byte_ctrl #(.WR_CYCLES(WR_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy_o(busy_o), .irq_o(irq_o), .stall_o(stall_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int due, input int sig, input logic val, input string req);
        exp_t e;
        int pos;
        e.due = due; e.sig = sig; e.val = val; e.req = req;
        pos = 0;
        while (pos < sb_q.size() && sb_q[pos].due <= due) pos++;
        sb_q.insert(pos, e);
    endtask

    // Monitor: compares busy (0), stall (1) and irq (2) at their due cycles.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                logic act;
                e = sb_q.pop_front();
                act = (e.sig == 0) ? busy_o : (e.sig == 1) ? stall_o : irq_o;
                if (e.due < cyc) check(1'b0, e.req, cyc, e.due);
                else check(act === e.val, e.req, int'(act), int'(e.val));
            end
        end
    end

    // Returns at the falling edge of the cycle whose rising edge sampled the write.
    task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
        bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_sel = 2'd3;
    endtask

    task automatic bus_read(input logic [1:0] sel, input logic [7:0] exp, input string req);
        bus_sel = sel;
        #1;
        check(bus_rdata === exp, req, int'(bus_rdata), int'(exp));
        bus_sel = 2'd3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full guarded write; gap = edges from the arm write to the strobe.
    task automatic guarded_write(input logic [6:0] a, input logic [7:0] d, input int gap,
                                 output int p);
        bus_write(2'd0, {1'b0, a});
        bus_write(2'd1, d);
        bus_write(2'd2, B_ARM | ie_b);
        idle(gap - 1);
        bus_write(2'd2, B_WR | ie_b);
        p = cyc;
    endtask

    task automatic fetch_and_check(input logic [6:0] a, input logic [7:0] exp, input string req);
        bus_write(2'd0, {1'b0, a});
        bus_write(2'd2, B_RD | ie_b);
        bus_read(2'd1, exp, req);
        idle(5);
    endtask

    initial begin
        int p;
        int a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: state after reset
        check(busy_o === 1'b0, "R6 reset busy", int'(busy_o), 0);
        check(stall_o === 1'b0, "R6 reset stall", int'(stall_o), 0);
        check(irq_o === 1'b0, "R6 reset irq", int'(irq_o), 0);
        bus_read(2'd2, 8'h00, "R6 reset control");
        bus_read(2'd1, 8'h00, "R6 reset data");

        // R2: bit 7 of the address register reads zero
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, 8'h7F, "R2 addr msb dropped");
        bus_write(2'd0, 8'h85);
        bus_read(2'd0, 8'h05, "R2 addr field");

        // R4 R7: first write, busy window and write stall
        guarded_write(7'h10, 8'hA5, 1, p);
        expect_at(p, 0, 1'b1, "R4 busy first cycle");
        expect_at(p + WR_CYC - 1, 0, 1'b1, "R4 busy last cycle");
        expect_at(p + WR_CYC, 0, 1'b0, "R4 busy cleared");
        expect_at(p, 1, 1'b1, "R7 write stall c0");
        expect_at(p + 1, 1, 1'b1, "R7 write stall c1");
        expect_at(p + 2, 1, 1'b0, "R7 write stall end");
        bus_read(2'd2, 8'h02, "R4 busy on control bit1, R3 arm consumed");
        idle(WR_CYC + 1);

        // R9 R7 R1: read strobe loads data register, read stall
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h10);
        bus_write(2'd2, B_RD);
        p = cyc;
        bus_read(2'd1, 8'hA5, "R9 read data due at strobe edge");
        expect_at(p + 3, 1, 1'b1, "R7 read stall c3");
        expect_at(p + 4, 1, 1'b0, "R7 read stall end");
        idle(6);

        // R3: strobe without arm, and arm plus strobe in one write
        bus_write(2'd2, B_WR);
        p = cyc;
        expect_at(p, 0, 1'b0, "R3 unarmed strobe ignored");
        expect_at(p, 1, 1'b0, "R7 ignored strobe no stall");
        idle(5);
        bus_write(2'd2, B_WR | B_ARM);
        a = cyc;
        expect_at(a, 0, 1'b0, "R3 same-write arm ignored");
        idle(2);
        bus_read(2'd2, 8'h04, "R3 arm visible c2");
        idle(1);
        bus_read(2'd2, 8'h04, "R3 arm visible c3");
        idle(1);
        bus_read(2'd2, 8'h00, "R3 arm expired c4");

        // R3: gap of 5 rejected, gap of 4 accepted at location 127
        guarded_write(7'h7F, 8'h99, 5, p);
        expect_at(p, 0, 1'b0, "R3 strobe after expiry ignored");
        idle(3);
        guarded_write(7'h7F, 8'h3C, 4, p);
        expect_at(p, 0, 1'b1, "R3 strobe at last arm cycle accepted");
        idle(WR_CYC + 1);
        fetch_and_check(7'h7F, 8'h3C, "R1 top location");
        guarded_write(7'h00, 8'h5A, 2, p);
        idle(WR_CYC + 1);
        fetch_and_check(7'h00, 8'h5A, "R1 bottom location");

        // R8: strobes while busy are ignored
        guarded_write(7'h20, 8'h66, 1, p);
        bus_write(2'd1, 8'h11);
        bus_write(2'd2, B_RD);
        expect_at(cyc, 1, 1'b0, "R8 busy read no stall");
        bus_read(2'd1, 8'h11, "R8 data register held");
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, B_ARM);
        bus_write(2'd2, B_WR);
        expect_at(p + WR_CYC - 1, 0, 1'b1, "R8 busy window unchanged");
        expect_at(p + WR_CYC, 0, 1'b0, "R8 busy ends on time");
        idle(WR_CYC);
        fetch_and_check(7'h00, 8'h5A, "R8 second write dropped");
        fetch_and_check(7'h20, 8'h66, "R8 captured byte committed");

        // R5: interrupt follows enable and busy
        ie_b = B_IE;
        bus_write(2'd2, B_IE);
        expect_at(cyc, 2, 1'b1, "R5 irq idle enabled");
        idle(1);
        guarded_write(7'h31, 8'h42, 1, p);
        expect_at(p, 2, 1'b0, "R5 irq low while busy");
        expect_at(p + WR_CYC, 2, 1'b1, "R5 irq back when ready");
        idle(WR_CYC + 1);

        // R6: reset during a commit
        guarded_write(7'h30, 8'hC3, 1, p);
        idle(2);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        ie_b = 8'h00;
        expect_at(p + 5, 0, 1'b1, "R6 busy through reset");
        expect_at(p + WR_CYC - 1, 0, 1'b1, "R6 busy until term");
        expect_at(p + WR_CYC, 0, 1'b0, "R6 commit ends on time");
        expect_at(p + WR_CYC, 2, 1'b0, "R6 enable cleared by reset");
        bus_read(2'd2, 8'h02, "R6 arm and enable cleared, busy kept");
        idle(WR_CYC);
        fetch_and_check(7'h30, 8'hC3, "R6 commit landed");

        idle(3);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual %0d expected finish", cyc);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule